// File: doc/BRIEF.md
# USB Host Interrupt and Error Reporter

This block sits beside the schedule engine and the bus-master read path of a USB 2.0 host controller. It gathers the completion, error and frame-rollover events, holds them as write-one-to-clear status bits, and drives one level-sensitive interrupt line. The line is the OR of every status bit gated by its enable. Transaction completion and transaction error events are held back by an interrupt-threshold interval measured in microframes. They are released at the first interval boundary after the status has been posted to the internal write buffer. The release does not wait for the memory write to finish.

When a read issued by the controller comes back with a master-abort or target-abort response, the block treats it as a fatal host error. It sets the host-error status bit and records the abort type in sticky bus-error bits. It also records a signaled system error when that reporting is enabled. It then lets at most one more USB transaction finish before it asserts the DMA halt output. Software restarts the controller with a run command, which is accepted only after the host-error bit has been cleared. Only the pin-style interrupt line exists; there is no message-based delivery.

Top module: `usbirq_top`

## Requirements
- R1: After reset, DMA halt is 1 and the interrupt line is 0. Status (address 1) reads 0x20, with only the halted bit 5 set. Control (address 0) reads 0x06 (threshold code 3 in bits [3:1], run bit 0 = 0, system-error enable bit 4 = 0). Enable (address 2) and bus-error (address 3) read 0.
- R2: Status bits 0..3 are write-one-to-clear through address 1. The interrupt line is a register holding the OR of status[3:0] AND enable[3:0]. It rises one cycle after an enabled status bit sets. It falls one cycle after the last enabled bit is cleared.
- R3: The threshold code T in control bits [3:1] selects an interval of 2^T microframes for T = 0..6; codes 7 and above act as 6. A boundary is a microframe tick, while running, on which the low T bits of the microframe index are all ones. The index counts ticks only while the controller is not halted.
- R4: A completion event (status bit 0) or a transaction-error event (status bit 1) stays pending and sets its status bit on the first boundary tick after the event cycle.
- R5: A read response with status code 1 (master abort) or 2 (target abort) sets host-error status bit 3. The interrupt line follows it only when enable bit 3 is set.
- R6: After an abort while running, DMA halt asserts in the cycle after the next transaction-end strobe or microframe tick, whichever comes first.
- R7: Bus-error bit 0 (master abort received) and bit 1 (target abort received) are set by their abort type. They are sticky until written with 1 at address 3.
- R8: When control bit 4 (system-error enable) is set, any abort also sets sticky bus-error bit 2. When control bit 4 is clear, bit 2 is left unchanged.
- R9: The frame-rollover status bit 2 sets on every 8192nd microframe tick while running, which is 1024 frames of 8 microframes.
- R10: Status bit 4 (data-buffer error) always reads 0, even after a write of all ones.
- R11: Status bit 5 reads 1 while DMA is halted. A write of control bit 0 = 1 leaves the halt in place while host-error bit 3 is set. After bit 3 has been cleared, the same write clears the halt.
- R12: A read response with status code 0 (OK) changes no status or bus-error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 enable, 3 bus error |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ev_done | input | 1 | Completion status posted to the write buffer |
| ev_err | input | 1 | Transaction-error status posted to the write buffer |
| xact_end | input | 1 | A USB transaction finished on the bus |
| uframe_tick | input | 1 | One pulse per microframe |
| rd_resp_valid | input | 1 | Bus-master read response strobe |
| rd_resp_status | input | 2 | Read response code: 0 OK, 1 master abort, 2 target abort |
| irq | output | 1 | Level interrupt line |
| dma_halt | output | 1 | Tells the DMA engines to stop |

## Verification
On every cycle, the assertions check these rules: the drain state ends in a halt after one more transaction or tick, a halt holds while host error is set, the abort bits stay sticky, an abort always reaches the host-error bit, and a thresholded bit never sets without a boundary. The frozen microframe index while halted is also checked. The exact number of ticks before a pending event is released, for each threshold code, and the clamping of oversized codes are shown only by the bench's vector table. The same holds for the 8192-tick rollover period, the interrupt-line latency on set and clear, and the run command being refused while host error is set.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

  typedef enum logic [1:0] {
    RESP_OK     = 2'd0,
    RESP_MABORT = 2'd1,
    RESP_TABORT = 2'd2
  } resp_e;

  typedef enum logic [1:0] {
    ST_HALT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } run_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STS  = 2'd1;
  localparam logic [1:0] ADDR_EN   = 2'd2;
  localparam logic [1:0] ADDR_BERR = 2'd3;

  localparam int SRC_DONE  = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_ROLL  = 2;
  localparam int SRC_HOST  = 3;
  localparam int NUM_SRC   = 4;

endpackage

// File: rtl/usbirq_uframe_timer.sv
module usbirq_uframe_timer #(
  parameter int UF_PER_FRAME  = 8,
  parameter int FRAME_ENTRIES = 1024,
  parameter int THR_LOG_MAX   = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       running,
  input  logic       uframe_tick,
  input  logic [2:0] thr_code,
  output logic       boundary,
  output logic       rollover
);
  localparam int IDX_W = $clog2(UF_PER_FRAME * FRAME_ENTRIES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(UF_PER_FRAME * FRAME_ENTRIES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [2:0]       thr_eff;
  logic [IDX_W-1:0] mask;
  logic             step;

  assign step    = uframe_tick && running;
  assign thr_eff = (thr_code > 3'(THR_LOG_MAX)) ? 3'(THR_LOG_MAX) : thr_code;
  assign mask    = (IDX_W'(1) << thr_eff) - IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       idx_q <= '0;
    else if (step) idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
  end

  assign boundary = step && ((idx_q & mask) == mask);
  assign rollover = step && (idx_q == IDX_LAST);

  AST_IDX_FROZEN_HALTED: assert property (@(posedge clk) disable iff (rst)
    !running |=> $stable(idx_q)); // R3

endmodule

// File: rtl/usbirq_fatal_ctl.sv
module usbirq_fatal_ctl
  import usbirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       abort_ma,
  input  logic       abort_ta,
  input  logic       serr_en,
  input  logic       xact_end,
  input  logic       uframe_tick,
  input  logic       run_cmd,
  input  logic       host_err,
  input  logic [2:0] berr_clr,
  output logic [2:0] berr,
  output logic       halted,
  output logic       running
);
  run_state_e state_q;
  logic       abort;
  logic [2:0] berr_set;

  assign abort    = abort_ma || abort_ta;
  assign berr_set = {abort && serr_en, abort_ta, abort_ma};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HALT;
    end else begin
      case (state_q)
        ST_RUN:   if (abort) state_q <= ST_DRAIN;
        ST_DRAIN: if (xact_end || uframe_tick) state_q <= ST_HALT;
        default:  if (run_cmd && !host_err && !abort) state_q <= ST_RUN;
      endcase
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_berr
    always_ff @(posedge clk) begin
      if (rst)              berr[i] <= 1'b0;
      else if (berr_set[i]) berr[i] <= 1'b1;
      else if (berr_clr[i]) berr[i] <= 1'b0;
    end
  end

  assign halted  = (state_q == ST_HALT);
  assign running = !halted;

  AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) && (xact_end || uframe_tick) |=> halted); // R6
  AST_HALT_HELD_ON_HOST_ERR: assert property (@(posedge clk) disable iff (rst)
    halted && host_err |=> halted); // R11
  AST_MABORT_STICKY: assert property (@(posedge clk) disable iff (rst)
    berr[0] && !berr_clr[0] |=> berr[0]); // R7
  AST_SERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    berr[2] && !berr_clr[2] |=> berr[2]); // R8

endmodule

// File: rtl/usbirq_status.sv
module usbirq_status
  import usbirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_done,
  input  logic               ev_err,
  input  logic               boundary,
  input  logic               rollover,
  input  logic               host_err_set,
  input  logic [NUM_SRC-1:0] clr_mask,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  output logic [NUM_SRC-1:0] sts,
  output logic [NUM_SRC-1:0] en,
  output logic               irq
);
  logic [1:0]         pend_q;
  logic [1:0]         ev_vec;
  logic [1:0]         release_v;
  logic [NUM_SRC-1:0] set_v;

  assign ev_vec = {ev_err, ev_done};

  for (genvar i = 0; i < 2; i++) begin : g_thr
    assign release_v[i] = pend_q[i] && boundary;
    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= ev_vec[i] || (pend_q[i] && !boundary);
    end
  end

  assign set_v = {host_err_set, rollover, release_v};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sts
    always_ff @(posedge clk) begin
      if (rst)            sts[i] <= 1'b0;
      else if (set_v[i])  sts[i] <= 1'b1;
      else if (clr_mask[i]) sts[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= '0;
      irq <= 1'b0;
    end else begin
      if (en_wr) en <= en_wdata;
      irq <= |(sts & en);
    end
  end

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !boundary && !sts[SRC_DONE] |=> !sts[SRC_DONE]); // R4
  AST_HOST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
    host_err_set |=> sts[SRC_HOST]); // R5

endmodule

// File: rtl/usbirq_top.sv
module usbirq_top
  import usbirq_pkg::*;
#(
  parameter int DW            = 32,
  parameter int AW            = 2,
  parameter int UF_PER_FRAME  = 8,
  parameter int FRAME_ENTRIES = 1024,
  parameter int THR_LOG_MAX   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_done,
  input  logic          ev_err,
  input  logic          xact_end,
  input  logic          uframe_tick,
  input  logic          rd_resp_valid,
  input  logic [1:0]    rd_resp_status,
  output logic          irq,
  output logic          dma_halt
);
  logic [2:0]         thr_q;
  logic               serr_en_q;
  logic               wr_ctrl, wr_sts, wr_en, wr_berr;
  logic               run_cmd;
  logic               abort_ma, abort_ta;
  logic               boundary, rollover;
  logic               halted, running;
  logic [NUM_SRC-1:0] sts, en;
  logic [2:0]         berr;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata[DW-1:5];

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_sts  = reg_wr && (reg_addr == ADDR_STS);
  assign wr_en   = reg_wr && (reg_addr == ADDR_EN);
  assign wr_berr = reg_wr && (reg_addr == ADDR_BERR);
  assign run_cmd = wr_ctrl && reg_wdata[0];

  assign abort_ma = rd_resp_valid && (rd_resp_status == RESP_MABORT);
  assign abort_ta = rd_resp_valid && (rd_resp_status == RESP_TABORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q     <= 3'd3;
      serr_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      thr_q     <= reg_wdata[3:1];
      serr_en_q <= reg_wdata[4];
    end
  end

  usbirq_uframe_timer #(
    .UF_PER_FRAME (UF_PER_FRAME),
    .FRAME_ENTRIES(FRAME_ENTRIES),
    .THR_LOG_MAX  (THR_LOG_MAX)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .running    (running),
    .uframe_tick(uframe_tick),
    .thr_code   (thr_q),
    .boundary   (boundary),
    .rollover   (rollover)
  );

  usbirq_fatal_ctl u_fatal (
    .clk        (clk),
    .rst        (rst),
    .abort_ma   (abort_ma),
    .abort_ta   (abort_ta),
    .serr_en    (serr_en_q),
    .xact_end   (xact_end),
    .uframe_tick(uframe_tick),
    .run_cmd    (run_cmd),
    .host_err   (sts[SRC_HOST]),
    .berr_clr   (wr_berr ? reg_wdata[2:0] : 3'b000),
    .berr       (berr),
    .halted     (halted),
    .running    (running)
  );

  usbirq_status u_status (
    .clk         (clk),
    .rst         (rst),
    .ev_done     (ev_done),
    .ev_err      (ev_err),
    .boundary    (boundary),
    .rollover    (rollover),
    .host_err_set(abort_ma || abort_ta),
    .clr_mask    (wr_sts ? reg_wdata[NUM_SRC-1:0] : '0),
    .en_wr       (wr_en),
    .en_wdata    (reg_wdata[NUM_SRC-1:0]),
    .sts         (sts),
    .en          (en),
    .irq         (irq)
  );

  assign dma_halt = halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= DW'({serr_en_q, thr_q, running});
        ADDR_STS:  reg_rdata <= DW'({halted, 1'b0, sts});
        ADDR_EN:   reg_rdata <= DW'(en);
        default:   reg_rdata <= DW'(berr);
      endcase
    end
  end

  AST_OK_RESP_NO_BERR: assert property (@(posedge clk) disable iff (rst)
    rd_resp_valid && (rd_resp_status == RESP_OK) && !berr[0] |=> !berr[0]); // R12
  AST_ROLLOVER_SETS: assert property (@(posedge clk) disable iff (rst)
    rollover |=> sts[SRC_ROLL]); // R9

endmodule

// File: tb/usbirq_top_bench.sv
module usbirq_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_done = 1'b0, ev_err = 1'b0, xact_end = 1'b0, uframe_tick = 1'b0;
  logic        rd_resp_valid = 1'b0;
  logic [1:0]  rd_resp_status = '0;
  logic        irq, dma_halt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  usbirq_top u_usbirq_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_done(ev_done), .ev_err(ev_err),
    .xact_end(xact_end), .uframe_tick(uframe_tick), .rd_resp_valid(rd_resp_valid),
    .rd_resp_status(rd_resp_status), .irq(irq), .dma_halt(dma_halt)
  );

  // {kind(0 done,1 err), thr code, ticks before event, ticks until release}
  localparam logic [15:0] VEC [9] = '{
    {1'b0, 3'd0, 6'd0,  6'd1},
    {1'b1, 3'd1, 6'd0,  6'd2},
    {1'b0, 3'd2, 6'd1,  6'd3},
    {1'b1, 3'd3, 6'd7,  6'd1},
    {1'b0, 3'd3, 6'd8,  6'd8},
    {1'b1, 3'd4, 6'd5,  6'd11},
    {1'b0, 3'd5, 6'd0,  6'd32},
    {1'b1, 3'd6, 6'd63, 6'd1},
    {1'b0, 3'd7, 6'd10, 6'd54}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); uframe_tick = 1'b1;
      repeat (n) @(negedge clk);
      uframe_tick = 1'b0;
    end
  endtask

  task automatic abort(input logic [1:0] code);
    @(negedge clk); rd_resp_valid = 1'b1; rd_resp_status = code;
    @(negedge clk); rd_resp_valid = 1'b0; rd_resp_status = 2'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R1 reset state
    @(negedge clk);
    check("R1 dma_halt", 32'(dma_halt), 32'd1);
    check("R1 irq", 32'(irq), 32'd0);
    rd(2'd1, d); check("R1 status", d, 32'h20);
    rd(2'd0, d); check("R1 control", d, 32'h06);
    rd(2'd2, d); check("R1 enable", d, 32'h0);
    rd(2'd3, d); check("R1 buserr", d, 32'h0);

    // R3 R4 threshold vectors
    for (int v = 0; v < 9; v++) begin
      logic       kind;
      logic [2:0] thr;
      int         pre, expn, bitpos;
      kind = VEC[v][15]; thr = VEC[v][14:12];
      pre = int'(VEC[v][11:6]); expn = int'(VEC[v][5:0]);
      bitpos = kind ? 1 : 0;
      do_reset();
      wr(2'd0, {28'd0, thr, 1'b1});
      ticks(pre);
      @(negedge clk); if (kind) ev_err = 1'b1; else ev_done = 1'b1;
      @(negedge clk); ev_err = 1'b0; ev_done = 1'b0;
      if (expn > 1) begin
        ticks(expn - 1);
        rd(2'd1, d); check("R3 R4 not before boundary", 32'(d[bitpos]), 32'd0);
      end
      ticks(1);
      rd(2'd1, d); check("R3 R4 released at boundary", 32'(d[bitpos]), 32'd1);
    end

    // R2 irq timing and W1C
    do_reset();
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h1);
    @(negedge clk); ev_done = 1'b1;
    @(negedge clk); ev_done = 1'b0;
    ticks(1);
    check("R2 irq lags status", 32'(irq), 32'd0);
    @(negedge clk);
    check("R2 irq raised", 32'(irq), 32'd1);
    wr(2'd1, 32'h1);
    check("R2 irq lags clear", 32'(irq), 32'd1);
    @(negedge clk);
    check("R2 irq dropped", 32'(irq), 32'd0);
    rd(2'd1, d); check("R2 W1C cleared", 32'(d[0]), 32'd0);

    // R5 R6 R7 R8 R11 master abort with serr and host-err enable
    do_reset();
    wr(2'd2, 32'h8);
    wr(2'd0, 32'h11);
    abort(2'd1);
    check("R6 no halt during drain", 32'(dma_halt), 32'd0);
    @(negedge clk);
    check("R5 irq on host error", 32'(irq), 32'd1);
    @(negedge clk); xact_end = 1'b1;
    @(negedge clk); xact_end = 1'b0;
    check("R6 halt after one more transaction", 32'(dma_halt), 32'd1);
    rd(2'd1, d); check("R5 R11 status host err and halted", d & 32'h28, 32'h28);
    rd(2'd3, d); check("R7 R8 master abort and serr", d, 32'h5);
    wr(2'd0, 32'h11);
    check("R11 run refused while host err", 32'(dma_halt), 32'd1);
    wr(2'd3, 32'h7);
    rd(2'd3, d); check("R7 buserr W1C", d, 32'h0);
    wr(2'd1, 32'h8);
    wr(2'd0, 32'h11);
    check("R11 run accepted after clear", 32'(dma_halt), 32'd0);
    rd(2'd1, d); check("R11 halted bit clear", 32'(d[5]), 32'd0);

    // R5 R6 R7 R8 target abort, no serr, host-err disabled, tick ends drain
    do_reset();
    wr(2'd0, 32'h01);
    abort(2'd2);
    ticks(1);
    check("R6 halt after tick", 32'(dma_halt), 32'd1);
    check("R5 irq masked", 32'(irq), 32'd0);
    rd(2'd3, d); check("R7 R8 target abort only", d, 32'h2);
    rd(2'd1, d); check("R5 host err status", 32'(d[3]), 32'd1);

    // R12 OK response has no effect
    do_reset();
    wr(2'd0, 32'h11);
    abort(2'd0);
    rd(2'd3, d); check("R12 buserr unchanged", d, 32'h0);
    rd(2'd1, d); check("R12 status unchanged", d, 32'h0);
    check("R12 still running", 32'(dma_halt), 32'd0);

    // R10 data-buffer bit
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R10 data-buffer bit zero", 32'(d[4]), 32'd0);

    // R9 rollover every 8192 ticks
    do_reset();
    wr(2'd0, 32'h1);
    ticks(8191);
    rd(2'd1, d); check("R9 no rollover at 8191", 32'(d[2]), 32'd0);
    ticks(1);
    rd(2'd1, d); check("R9 rollover at 8192", 32'(d[2]), 32'd1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule